// File: doc/BRIEF.md
# Printer Output Ready-Flag Controller

This block is the printer side of the I/O port of a 12-bit accumulator machine. When the processor runs an I/O transfer instruction that selects the printer, it presents the instruction's low three bits as a function code, with a one-cycle strobe. The block keeps a single "printer ready" flag. It can set that flag, clear it, or test it for a conditional skip. It can also hand the low byte of the accumulator to a character transmitter through a valid/ready handshake. One skip code also looks at the ready flag of the keyboard interface, which comes in on a port. In this way one instruction can poll both devices.

The skip decision and the next program counter are combinational within the strobe cycle. A skip advances the PC by one, and the increment wraps within 12 bits. The flag, the character and the valid line are registered. When the transmitter takes a character, the ready flag rises again. A clear requested by an instruction in that same cycle takes priority.

Top module: `printer_port`

## Requirements
- R1: During and after an asynchronous active-low reset, `out_flag`, `tx_valid` and `tx_data` are 0.
- R2: A strobed code 0 makes `out_flag` 1 after the next clock edge.
- R3: A strobed code 2 makes `out_flag` 0 after the next clock edge. This holds even when the transmitter accepts a character in the same cycle.
- R4: A strobed code 1 drives `skip_req` equal to the current `out_flag` in the strobe cycle.
- R5: A strobed code 5 drives `skip_req` to the OR of `out_flag` and `kbd_flag` in the strobe cycle.
- R6: `pc_next` equals `(pc_in + 1) mod 4096` while `skip_req` is 1, and equals `pc_in` otherwise.
- R7: A strobed code 4, accepted as in R11, loads `acc_in[7:0]` into `tx_data` and raises `tx_valid` after the edge. `out_flag` is left as it was.
- R8: A strobed code 6, accepted as in R11, loads the character as in R7 and clears `out_flag`. The clear takes priority over a same-cycle acceptance.
- R9: While `tx_valid` is 1 and `tx_ready` is 0, `tx_valid` and `tx_data` hold their values.
- R10: A cycle with `tx_valid` and `tx_ready` both 1 transfers the character. `out_flag` becomes 1 unless that cycle also clears it. `tx_valid` falls unless a new character loads in that cycle.
- R11: A print code (4 or 6) that arrives while a character is waiting (`tx_valid` 1, `tx_ready` 0) has no effect: the flag and the character are unchanged.
- R12: Codes 3 and 7, and any cycle with `iot_valid` at 0, request no skip and change neither the flag nor the transmitter state. Acceptance by the transmitter still takes effect in such a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| iot_valid | input | 1 | Printer I/O instruction strobe, one cycle |
| iot_func | input | 3 | Function code from the instruction's low bits |
| acc_in | input | 12 | Accumulator value |
| pc_in | input | 12 | Program counter already advanced past the instruction |
| kbd_flag | input | 1 | Keyboard ready flag |
| skip_req | output | 1 | Skip request for the current strobe |
| pc_next | output | 12 | Program counter after any skip |
| out_flag | output | 1 | Printer ready flag |
| tx_valid | output | 1 | Character valid toward the transmitter |
| tx_data | output | 8 | Character toward the transmitter |
| tx_ready | input | 1 | Transmitter accepts the character |

## Verification
Some behaviours are checked by assertions on every cycle:
- the decoder asserts at most one operation at a time and none for the idle codes;
- the flag follows set and clear commands one edge later;
- a waiting character holds still;
- an acceptance with no reload drops the valid line;
- the skip and PC outputs match the flag tests and the 12-bit wrap.

Other behaviours only the bench's scenarios can show. These include the priority of an instruction clear over an acceptance, and a print being ignored while the transmitter stalls. They also include an acceptance and a reload in the same cycle, and the whole effect of a code sequence on the ports.

// File: rtl/printer_port_pkg.sv
package printer_port_pkg;

  localparam int FUNC_W = 3;

  typedef enum logic [FUNC_W-1:0] {
    FN_SET       = 3'd0,
    FN_SKIP_RDY  = 3'd1,
    FN_CLEAR     = 3'd2,
    FN_IDLE_A    = 3'd3,
    FN_SEND      = 3'd4,
    FN_SKIP_ANY  = 3'd5,
    FN_SEND_CLR  = 3'd6,
    FN_IDLE_B    = 3'd7
  } pp_func_e;

  typedef struct packed {
    logic set_flag;
    logic clr_flag;
    logic send_keep;
    logic send_clr;
    logic skip_rdy;
    logic skip_any;
  } pp_ops_t;

endpackage

// File: rtl/pp_decode.sv
module pp_decode
  import printer_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iot_valid,
  input  logic [FUNC_W-1:0] iot_func,
  output pp_ops_t           ops
);

  always_comb begin
    ops = '0;
    if (iot_valid) begin
      case (pp_func_e'(iot_func))
        FN_SET:      ops.set_flag  = 1'b1;
        FN_SKIP_RDY: ops.skip_rdy  = 1'b1;
        FN_CLEAR:    ops.clr_flag  = 1'b1;
        FN_SEND:     ops.send_keep = 1'b1;
        FN_SKIP_ANY: ops.skip_any  = 1'b1;
        FN_SEND_CLR: ops.send_clr  = 1'b1;
        default:     ops = '0;
      endcase
    end
  end

  // Each code maps to at most one operation.
  assert_ops_onehot_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ops));

  // The idle codes and a missing strobe produce no operation.
  assert_idle_codes_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!iot_valid || iot_func == 3'd3 || iot_func == 3'd7) |-> (ops == '0));

endmodule

// File: rtl/pp_ready_flag.sv
module pp_ready_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_cmd,
  input  logic clr_cmd,
  input  logic accept,
  output logic flag_q
);

  logic flag_d;

  // Instruction commands override the set caused by acceptance.
  always_comb begin
    flag_d = flag_q;
    if (accept)  flag_d = 1'b1;
    if (set_cmd) flag_d = 1'b1;
    if (clr_cmd) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assert_flag_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    set_cmd |=> flag_q);

  assert_flag_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_cmd |=> !flag_q);

  assert_accept_sets_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !clr_cmd) |=> flag_q);

  assert_flag_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_cmd && !clr_cmd && !accept) |=> $stable(flag_q));

endmodule

// File: rtl/pp_char_buf.sv
module pp_char_buf #(
  parameter int ACC_W  = 12,
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_req,
  input  logic [ACC_W-1:0]  acc,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic [CHAR_W-1:0] tx_data,
  output logic              load_taken,
  output logic              accept
);

  function automatic logic [CHAR_W-1:0] char_of(input logic [ACC_W-1:0] a);
    return a[CHAR_W-1:0];
  endfunction

  logic stalled;

  assign accept     = tx_valid && tx_ready;
  assign stalled    = tx_valid && !tx_ready;
  assign load_taken = load_req && !stalled;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else if (load_taken) begin
      tx_valid <= 1'b1;
      tx_data  <= char_of(acc);
    end else if (accept) begin
      tx_valid <= 1'b0;
    end
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stalled |=> (tx_valid && $stable(tx_data)));

  assert_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load_taken |=> (tx_valid && tx_data == $past(acc[CHAR_W-1:0])));

  assert_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !load_req) |=> !tx_valid);

  assert_busy_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (load_req && stalled) |-> !load_taken);

endmodule

// File: rtl/printer_port.sv
module printer_port
  import printer_port_pkg::*;
#(
  parameter int ACC_W  = 12,
  parameter int PC_W   = 12,
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iot_valid,
  input  logic [FUNC_W-1:0] iot_func,
  input  logic [ACC_W-1:0]  acc_in,
  input  logic [PC_W-1:0]   pc_in,
  input  logic              kbd_flag,
  output logic              skip_req,
  output logic [PC_W-1:0]   pc_next,
  output logic              out_flag,
  output logic              tx_valid,
  output logic [CHAR_W-1:0] tx_data,
  input  logic              tx_ready
);

  localparam logic [PC_W-1:0] PC_ONE = PC_W'(1);

  function automatic logic [PC_W-1:0] pc_after(input logic [PC_W-1:0] pc, input logic skip);
    return skip ? pc + PC_ONE : pc;
  endfunction

  pp_ops_t ops;
  logic    load_req;
  logic    load_taken;
  logic    accept;
  logic    clr_cmd;

  pp_decode u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .iot_valid (iot_valid),
    .iot_func  (iot_func),
    .ops       (ops)
  );

  assign load_req = ops.send_keep || ops.send_clr;
  assign clr_cmd  = ops.clr_flag || (ops.send_clr && load_taken);

  pp_char_buf #(.ACC_W(ACC_W), .CHAR_W(CHAR_W)) u_buf (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_req   (load_req),
    .acc        (acc_in),
    .tx_ready   (tx_ready),
    .tx_valid   (tx_valid),
    .tx_data    (tx_data),
    .load_taken (load_taken),
    .accept     (accept)
  );

  pp_ready_flag u_flag (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_cmd (ops.set_flag),
    .clr_cmd (clr_cmd),
    .accept  (accept),
    .flag_q  (out_flag)
  );

  assign skip_req = (ops.skip_rdy && out_flag) ||
                    (ops.skip_any && (out_flag || kbd_flag));
  assign pc_next  = pc_after(pc_in, skip_req);

  assert_skip_rdy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (iot_valid && iot_func == 3'd1) |-> (skip_req == out_flag));

  assert_skip_any_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (iot_valid && iot_func == 3'd5 && kbd_flag) |-> skip_req);

  assert_pc_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    skip_req |-> (pc_next == pc_in + PC_ONE));

  assert_pc_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !skip_req |-> (pc_next == pc_in));

  assert_skip_strobed_R12: assert property (@(posedge clk) disable iff (!rst_n)
    skip_req |-> iot_valid);

  assert_send_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (iot_valid && iot_func == 3'd6 && !(tx_valid && !tx_ready)) |=> (!out_flag && tx_valid));

endmodule

// File: tb/printer_port_test.sv
module printer_port_test;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 17;

  typedef struct packed {
    logic        vld;
    logic [2:0]  fn;
    logic [11:0] acc;
    logic [11:0] pc;
    logic        kbd;
    logic        rdy;
    logic        e_skip;
    logic [11:0] e_pcn;
    logic        e_flag;
    logic        e_v;
    logic [7:0]  e_d;
  } vec_t;

  // Each row is one strobe cycle; expectations are the combinational outputs
  // in that cycle and the registered state after its edge.
  localparam vec_t VECS [NVEC] = '{
    '{1'b1,3'd1,12'h000,12'h100,1'b0,1'b0, 1'b0,12'h100, 1'b0,1'b0,8'h00}, // R4 flag clear
    '{1'b1,3'd5,12'h000,12'h200,1'b1,1'b0, 1'b1,12'h201, 1'b0,1'b0,8'h00}, // R5 via kbd
    '{1'b1,3'd0,12'h000,12'h300,1'b0,1'b0, 1'b0,12'h300, 1'b1,1'b0,8'h00}, // R2
    '{1'b1,3'd1,12'h000,12'hFFF,1'b0,1'b0, 1'b1,12'h000, 1'b1,1'b0,8'h00}, // R4 R6 wrap
    '{1'b1,3'd5,12'h000,12'h010,1'b0,1'b0, 1'b1,12'h011, 1'b1,1'b0,8'h00}, // R5 via flag
    '{1'b1,3'd4,12'hA5C,12'h020,1'b0,1'b0, 1'b0,12'h020, 1'b1,1'b1,8'h5C}, // R7
    '{1'b1,3'd6,12'h123,12'h030,1'b0,1'b0, 1'b0,12'h030, 1'b1,1'b1,8'h5C}, // R11 R9
    '{1'b1,3'd3,12'h777,12'h040,1'b1,1'b0, 1'b0,12'h040, 1'b1,1'b1,8'h5C}, // R12 R9
    '{1'b1,3'd2,12'h000,12'h050,1'b0,1'b1, 1'b0,12'h050, 1'b0,1'b0,8'h5C}, // R3 over accept
    '{1'b1,3'd6,12'hFEE,12'h060,1'b0,1'b0, 1'b0,12'h060, 1'b0,1'b1,8'hEE}, // R8
    '{1'b0,3'd0,12'h000,12'h070,1'b0,1'b0, 1'b0,12'h070, 1'b0,1'b1,8'hEE}, // R12 no strobe
    '{1'b1,3'd7,12'h000,12'h080,1'b1,1'b1, 1'b0,12'h080, 1'b1,1'b0,8'hEE}, // R12 R10
    '{1'b1,3'd4,12'h0FF,12'h090,1'b0,1'b0, 1'b0,12'h090, 1'b1,1'b1,8'hFF}, // R7
    '{1'b1,3'd6,12'h401,12'h0A0,1'b0,1'b1, 1'b0,12'h0A0, 1'b0,1'b1,8'h01}, // R8 R10 reload
    '{1'b1,3'd1,12'h000,12'h7FF,1'b0,1'b0, 1'b0,12'h7FF, 1'b0,1'b1,8'h01}, // R4 R6
    '{1'b1,3'd5,12'h000,12'h7FE,1'b0,1'b0, 1'b0,12'h7FE, 1'b0,1'b1,8'h01}, // R5 none
    '{1'b1,3'd2,12'h000,12'h0B0,1'b0,1'b1, 1'b0,12'h0B0, 1'b0,1'b0,8'h01}  // R3 R10
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        iot_valid = 1'b0;
  logic [2:0]  iot_func = 3'd0;
  logic [11:0] acc_in = '0;
  logic [11:0] pc_in = '0;
  logic        kbd_flag = 1'b0;
  logic        tx_ready = 1'b0;
  logic        skip_req;
  logic [11:0] pc_next;
  logic        out_flag;
  logic        tx_valid;
  logic [7:0]  tx_data;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  printer_port uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .iot_valid (iot_valid),
    .iot_func  (iot_func),
    .acc_in    (acc_in),
    .pc_in     (pc_in),
    .kbd_flag  (kbd_flag),
    .skip_req  (skip_req),
    .pc_next   (pc_next),
    .out_flag  (out_flag),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .tx_ready  (tx_ready)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [2:0] f, input logic [11:0] a,
                       input logic [11:0] p, input logic k, input logic r);
    iot_valid = v; iot_func = f; acc_in = a; pc_in = p; kbd_flag = k; tx_ready = r;
  endtask

  initial begin
    repeat (2) @(posedge clk);
    #1;
    chk("R1", "flag in reset", out_flag, 0);
    chk("R1", "valid in reset", tx_valid, 0);
    chk("R1", "data in reset", tx_data, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1", "flag after reset", out_flag, 0);

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      drive(VECS[i].vld, VECS[i].fn, VECS[i].acc, VECS[i].pc, VECS[i].kbd, VECS[i].rdy);
      #1;
      chk("R4 R5 R12", $sformatf("skip row %0d", i), skip_req, VECS[i].e_skip);
      chk("R6", $sformatf("pc_next row %0d", i), pc_next, VECS[i].e_pcn);
      @(posedge clk); #1;
      chk("R2 R3 R8 R10 R12", $sformatf("flag row %0d", i), out_flag, VECS[i].e_flag);
      chk("R7 R9 R10 R11", $sformatf("valid row %0d", i), tx_valid, VECS[i].e_v);
      chk("R7 R9 R11", $sformatf("data row %0d", i), tx_data, VECS[i].e_d);
    end

    // R12: idle code 7 while a character waits leaves everything untouched
    @(negedge clk); drive(1'b1, 3'd4, 12'h03C, 12'h0, 1'b0, 1'b0);
    @(negedge clk); drive(1'b1, 3'd7, 12'hFFF, 12'h0, 1'b1, 1'b0);
    #1; chk("R12", "skip on code 7", skip_req, 0);
    @(posedge clk); #1;
    chk("R12", "flag after code 7", out_flag, 0);
    chk("R12", "data after code 7", tx_data, 8'h3C);

    // R1: reset in the middle of a pending character
    @(negedge clk); drive(1'b1, 3'd0, 12'h0, 12'h0, 1'b0, 1'b0);
    @(negedge clk); drive(1'b0, 3'd0, 12'h0, 12'h0, 1'b0, 1'b0);
    chk("R2", "flag before reset", out_flag, 1);
    rst_n = 1'b0;
    #1;
    chk("R1", "flag mid reset", out_flag, 0);
    chk("R1", "valid mid reset", tx_valid, 0);
    chk("R1", "data mid reset", tx_data, 0);
    @(negedge clk); rst_n = 1'b1;

    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule